// File: doc/BRIEF.md
# Read-Only SPI Drain Port for a Circular Receive Buffer

This block lets a host pull received words out of an eight-entry circular buffer over a second, listen-only SPI port. A producer in the system clock domain writes entries with a one-cycle push strobe. Each entry holds a 12-bit data field and a 4-bit status tag. The host sees each entry as one 16-bit word on MISO.

The SPI port has a chip select, a clock and a data output, and no data input. The host cannot change anything in the block except to remove the oldest entry, and it does that by clocking out a complete frame. The SPI clock is unrelated to the system clock. Read and write positions cross between the two domains as Gray-coded pointers through two-flop synchronizers. A push into a full buffer is dropped, and a sticky flag in the system domain records the drop.

The SPI side only sees new entries on its own clock edges. The host therefore gives two SCLK rising edges with chip select high (a refresh preamble) before a frame that should see pushes made while SCLK was idle.

Top module: `spi_rdbuf_top`

## Requirements
- R1: A frame shifts out one 16-bit word, most significant bit first. The word carries the tag in bits 15:12 and the data in bits 11:0. The first bit is on MISO once chip select is low and before the first SCLK rising edge. Each later bit appears after an SCLK falling edge, so the host samples on rising edges.
- R2: While chip select is high, `miso_oe_o` is 0 and `miso_o` is 0. While chip select is low, `miso_oe_o` is 1.
- R3: A frame that sees at least 16 SCLK rising edges removes the entry it showed. Successive complete frames return the entries in push order.
- R4: If chip select rises before the 16th rising edge, the frame is aborted. The bits already sent are the leading bits of the head word, and the next frame shows that same entry again.
- R5: A frame started while the buffer is empty returns 16 zero bits and removes nothing. A word pushed afterwards is the next word read.
- R6: `full_o` is 1 exactly when eight entries are held. A push while `full_o` is 1 is dropped and leaves the stored entries unchanged.
- R7: `overflow_o` is set by a dropped push. Frames and later pushes do not clear it; only reset does.
- R8: A push is visible to a frame that follows a refresh preamble given at least one system clock cycle after the push. After a frame removes an entry, `full_o` falls within four system clock cycles.
- R9: After reset, `full_o` and `overflow_o` are 0 and the buffer is empty.
- R10: SCLK rising edges beyond the 16th in the same frame neither remove a second entry nor skip one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, synchronous in the system domain, asynchronous clear of the SPI domain |
| push_i | input | 1 | Push strobe, one entry per cycle |
| push_data_i | input | 12 | Data field of the pushed entry |
| push_tag_i | input | 4 | Status tag of the pushed entry |
| full_o | output | 1 | Buffer holds eight entries |
| overflow_o | output | 1 | Sticky flag: a push was dropped |
| sclk_i | input | 1 | SPI clock, idle low |
| csb_i | input | 1 | SPI chip select, active low |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for the MISO pad |

## Verification
A wrong read pointer shows up at the port in the very next complete frame: the word is a repeat, a skip or a stale entry instead of the next one in push order. A wrong write pointer or a wrong full decision shows up on `full_o` or `overflow_o` in the cycle after the push that ought to fill the buffer or be dropped. A bad Gray crossing keeps `full_o` high for longer than its four-cycle bound after a pop. Aborted frames, frames with extra clocks and frames on an empty buffer each expose a wrongly timed pop on the frame after them.

// File: rtl/spi_rdbuf_pkg.sv
package spi_rdbuf_pkg;
  localparam int FRAME_W = 16;
  localparam int TAG_W   = 4;
  localparam int DATA_W  = FRAME_W - TAG_W;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/rdbuf_sync.sv
module rdbuf_sync #(
  parameter int W          = 4,
  parameter bit ASYNC_CLR  = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          stage1 <= '0;
          stage2 <= '0;
        end else begin
          stage1 <= d;
          stage2 <= stage1;
        end
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          stage1 <= '0;
          stage2 <= '0;
        end else begin
          stage1 <= d;
          stage2 <= stage1;
        end
      end
    end
  endgenerate

  assign q = stage2;
endmodule

// File: rtl/rdbuf_mem.sv
module rdbuf_mem
  import spi_rdbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  entry_t        wdata,
  input  logic [AW-1:0] raddr,
  output entry_t        rdata
);
  entry_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/rdbuf_wr_side.sv
module rdbuf_wr_side #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [PW-1:0] rd_gray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wr_gray,
  output logic          full,
  output logic          overflow
);
  logic [PW-1:0] wr_bin;
  logic [PW-1:0] wr_bin_nxt;

  assign wr_bin_nxt = wr_bin + PW'(1);
  assign full  = (wr_gray == {~rd_gray_s[PW-1:PW-2], rd_gray_s[PW-3:0]});
  assign we    = push && !full;
  assign waddr = wr_bin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bin   <= '0;
      wr_gray  <= '0;
      overflow <= 1'b0;
    end else if (push) begin
      if (full) begin
        overflow <= 1'b1;
      end else begin
        wr_bin  <= wr_bin_nxt;
        wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
      end
    end
  end
endmodule

// File: rtl/rdbuf_spi_side.sv
module rdbuf_spi_side
  import spi_rdbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int CW   = $clog2(FRAME_W) + 1,
  localparam int IW   = $clog2(FRAME_W)
) (
  input  logic          rst,
  input  logic          sclk,
  input  logic          csb,
  input  logic [PW-1:0] wr_gray_s,
  input  entry_t        rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rd_gray,
  output logic [CW-1:0] bit_cnt,
  output logic          frame_empty,
  output logic          miso,
  output logic          miso_oe
);
  logic [PW-1:0]      rd_bin;
  logic [PW-1:0]      rd_bin_nxt;
  logic               empty_now;
  logic [FRAME_W-1:0] live_word;
  logic [FRAME_W-1:0] word_q;
  logic [IW-1:0]      bit_idx;
  logic               cur_bit;

  assign empty_now  = (rd_gray == wr_gray_s);
  assign live_word  = empty_now ? '0 : rdata;
  assign raddr      = rd_bin[AW-1:0];
  assign rd_bin_nxt = rd_bin + PW'(1);

  // rising edges seen in the current frame, saturating after the last bit
  always_ff @(posedge sclk or posedge csb) begin
    if (csb) bit_cnt <= '0;
    else if (bit_cnt != CW'(FRAME_W)) bit_cnt <= bit_cnt + CW'(1);
  end

  // snapshot of the head word at the first rising edge of a frame
  always_ff @(posedge sclk or posedge rst) begin
    if (rst) begin
      word_q      <= '0;
      frame_empty <= 1'b1;
    end else if (!csb && bit_cnt == '0) begin
      word_q      <= live_word;
      frame_empty <= empty_now;
    end
  end

  // pop on the edge that samples the final bit
  always_ff @(posedge sclk or posedge rst) begin
    if (rst) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else if (!csb && bit_cnt == CW'(FRAME_W - 1) && !frame_empty) begin
      rd_bin  <= rd_bin_nxt;
      rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
    end
  end

  // output bit index advances on falling edges
  always_ff @(negedge sclk or posedge csb) begin
    if (csb) bit_idx <= IW'(FRAME_W - 1);
    else if (bit_idx != '0) bit_idx <= bit_idx - IW'(1);
  end

  assign cur_bit = (bit_cnt == '0) ? live_word[FRAME_W-1] : word_q[bit_idx];
  assign miso    = csb ? 1'b0 : cur_bit;
  assign miso_oe = !csb;
endmodule

// File: rtl/spi_rdbuf_top.sv
module spi_rdbuf_top
  import spi_rdbuf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  output logic              full_o,
  output logic              overflow_o,
  input  logic              sclk_i,
  input  logic              csb_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(FRAME_W) + 1;

  entry_t        wr_entry;
  entry_t        rd_entry;
  logic          we;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [PW-1:0] wr_gray;
  logic [PW-1:0] wr_gray_s;
  logic [PW-1:0] rd_gray;
  logic [PW-1:0] rd_gray_s;
  logic [CW-1:0] bit_cnt;
  logic          frame_empty;

  assign wr_entry = {push_tag_i, push_data_i};

  rdbuf_mem #(.DEPTH(DEPTH)) mem_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wr_entry),
    .raddr(raddr), .rdata(rd_entry)
  );

  rdbuf_wr_side #(.DEPTH(DEPTH)) wr_i (
    .clk(clk), .rst(rst), .push(push_i), .rd_gray_s(rd_gray_s),
    .we(we), .waddr(waddr), .wr_gray(wr_gray),
    .full(full_o), .overflow(overflow_o)
  );

  rdbuf_sync #(.W(PW), .ASYNC_CLR(1'b0)) rd2wr_i (
    .clk(clk), .rst(rst), .d(rd_gray), .q(rd_gray_s)
  );

  rdbuf_sync #(.W(PW), .ASYNC_CLR(1'b1)) wr2rd_i (
    .clk(sclk_i), .rst(rst), .d(wr_gray), .q(wr_gray_s)
  );

  rdbuf_spi_side #(.DEPTH(DEPTH)) spi_i (
    .rst(rst), .sclk(sclk_i), .csb(csb_i), .wr_gray_s(wr_gray_s),
    .rdata(rd_entry), .raddr(raddr), .rd_gray(rd_gray),
    .bit_cnt(bit_cnt), .frame_empty(frame_empty),
    .miso(miso_o), .miso_oe(miso_oe_o)
  );
endmodule

// File: rtl/spi_rdbuf_chk.sv
module spi_rdbuf_chk #(
  parameter int PW = 4,
  parameter int CW = 5,
  parameter int LAST_BIT = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          sclk_i,
  input logic          push_i,
  input logic          full_o,
  input logic          overflow_o,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_gray,
  input logic [PW-1:0] rd_gray_s,
  input logic [CW-1:0] bit_cnt,
  input logic          frame_empty
);
  // R6: a push while full leaves the write position alone
  a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
    (push_i && full_o) |=> (wr_gray == $past(wr_gray)));

  // R7: a dropped push raises the sticky flag
  a_r7_ovf_set: assert property (@(posedge clk) disable iff (rst)
    (push_i && full_o) |=> overflow_o);

  // R7: the flag holds until reset
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);

  // R8: the crossed read position moves by at most one Gray bit per cycle
  a_r8_rd_gray_step: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_gray_s ^ $past(rd_gray_s)) <= 1);

  // R8: the write position moves by at most one Gray bit per cycle
  a_r8_wr_gray_step: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  // R3: the read position only moves on the edge that completes a frame
  a_r3_pop_at_end: assert property (@(posedge sclk_i) disable iff (rst)
    (rd_gray != $past(rd_gray)) |-> ($past(bit_cnt) == CW'(LAST_BIT)));

  // R5: a frame that started empty never removes an entry
  a_r5_no_pop_empty: assert property (@(posedge sclk_i) disable iff (rst)
    (rd_gray != $past(rd_gray)) |-> !$past(frame_empty));
endmodule

bind spi_rdbuf_top spi_rdbuf_chk #(.PW(PW), .CW(CW), .LAST_BIT(FRAME_W - 1)) chk_i (
  .clk(clk), .rst(rst), .sclk_i(sclk_i), .push_i(push_i),
  .full_o(full_o), .overflow_o(overflow_o), .wr_gray(wr_gray),
  .rd_gray(rd_gray), .rd_gray_s(rd_gray_s), .bit_cnt(bit_cnt),
  .frame_empty(frame_empty)
);

// File: tb/spi_rdbuf_tb.sv
`timescale 1ns/1ps
module spi_rdbuf_top_tb_top;
  localparam int DEPTH = 8;
  localparam real SHP  = 23.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 1'b0;
  logic [11:0] push_data_i = '0;
  logic [3:0]  push_tag_i = '0;
  logic        full_o, overflow_o;
  logic        sclk_i = 1'b0;
  logic        csb_i = 1'b1;
  logic        miso_o, miso_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] q_m [DEPTH];
  int          head_m = 0;
  int          cnt_m = 0;
  bit          ovf_m = 1'b0;

  always #4 clk = ~clk;

  spi_rdbuf_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .push_i(push_i), .push_data_i(push_data_i),
    .push_tag_i(push_tag_i), .full_o(full_o), .overflow_o(overflow_o),
    .sclk_i(sclk_i), .csb_i(csb_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o)
  );

  function automatic logic [15:0] head_word();
    return (cnt_m == 0) ? 16'h0000 : q_m[head_m];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sclk_pulse();
    sclk_i = 1'b1; #(SHP);
    sclk_i = 1'b0; #(SHP);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    csb_i = 1'b1;
    repeat (3) sclk_pulse();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    head_m = 0; cnt_m = 0; ovf_m = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input logic [11:0] d, input logic [3:0] t);
    @(negedge clk);
    push_i = 1'b1; push_data_i = d; push_tag_i = t;
    @(negedge clk);
    push_i = 1'b0;
    if (cnt_m == DEPTH) ovf_m = 1'b1;
    else begin
      q_m[(head_m + cnt_m) % DEPTH] = {t, d};
      cnt_m++;
    end
  endtask

  // refresh preamble then a frame of n rising edges; returns the sampled bits
  task automatic frame(input int n, output logic [31:0] bits);
    bits = '0;
    repeat (2) @(negedge clk);
    repeat (2) sclk_pulse();
    csb_i = 1'b0; #(SHP);
    for (int i = 0; i < n; i++) begin
      if (!miso_oe_o) check(1'b0, "R2 oe low in frame", miso_oe_o, 1);
      bits = {bits[30:0], miso_o};
      sclk_pulse();
    end
    csb_i = 1'b1; #(SHP);
    repeat (6) @(negedge clk);
  endtask

  task automatic read_full(input int n, input string req);
    logic [31:0] got;
    logic [15:0] exp;
    exp = head_word();
    frame(n, got);
    check(got[n-1 -: 16] == exp, req, got[n-1 -: 16], exp);
    if (cnt_m > 0) begin
      head_m = (head_m + 1) % DEPTH;
      cnt_m--;
    end
  endtask

  task automatic read_abort(input int n);
    logic [31:0] got;
    logic [15:0] exp;
    exp = head_word();
    frame(n, got);
    check(got[15:0] == 16'(exp >> (16 - n)), "R4 aborted prefix", got[15:0],
          16'(exp >> (16 - n)));
  endtask

  task automatic check_flags(input string req);
    check(full_o == (cnt_m == DEPTH), req, full_o, cnt_m == DEPTH);
    check(overflow_o == ovf_m, "R7 overflow flag", overflow_o, ovf_m);
  endtask

  initial begin
    #(150000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R9 reset state
    check(full_o == 1'b0, "R9 full after reset", full_o, 0);
    check(overflow_o == 1'b0, "R9 overflow after reset", overflow_o, 0);
    // R2 idle pad
    check(miso_oe_o == 1'b0 && miso_o == 1'b0, "R2 idle pad", {miso_oe_o, miso_o}, 0);
    // R9 / R5 empty read returns zeros
    read_full(16, "R9 empty after reset");
    read_full(16, "R5 empty read zeros");
    // R1 tag placement, R5 push after empty read
    push(12'hABC, 4'h5);
    read_full(16, "R1 R5 R8 word layout 16'h5ABC");
    // R3 ordering
    push(12'h123, 4'h1); push(12'h456, 4'h2); push(12'h789, 4'hF);
    read_full(16, "R3 order 1");
    read_full(16, "R3 order 2");
    // R4 abort then same entry again
    read_abort(7);
    read_full(16, "R4 entry kept after abort");
    // R10 extra clocks
    push(12'h0F0, 4'h3); push(12'hF0F, 4'hC);
    read_full(20, "R10 extra clocks single pop");
    read_full(16, "R10 next entry not skipped");
    // R6 / R7 fill and overflow
    for (int i = 0; i < DEPTH; i++) push(12'(i * 37), 4'(i));
    check_flags("R6 full at eight");
    push(12'hDEA, 4'hD);
    check_flags("R6 R7 dropped push");
    read_full(16, "R6 contents unchanged after drop");
    check(full_o == 1'b0, "R8 full falls after pop", full_o, 0);
    check(overflow_o == 1'b1, "R7 sticky after read", overflow_o, 1);
    // constrained random
    for (int it = 0; it < 250; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 5) push(12'($urandom), 4'($urandom));
      else if (op < 8) read_full(16, "R3 random read");
      else if (op == 8) read_abort(int'($urandom_range(1, 15)));
      else read_full(int'($urandom_range(17, 24)), "R10 random long frame");
      check_flags("R6 random full");
    end
    // R7 cleared only by reset
    do_reset();
    check(overflow_o == 1'b0, "R7 cleared by reset", overflow_o, 0);
    check(full_o == 1'b0, "R9 full after second reset", full_o, 0);
    read_full(16, "R9 empty after second reset");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule